// File: doc/BRIEF.md
# Opcode Class and Length Decoder

This block classifies one 8-bit opcode byte of a small accumulator machine's instruction set. It reports the class of the instruction, the total instruction length (one to three bytes), and the register, ALU-operation and condition fields that the class actually uses. It also reports whether an operand is the memory location addressed by the H:L register pair, and the number carried by an external-command opcode together with its validity. The opcode map is irregular. Two separate patterns mean HALT. The move from the accumulator to itself is a NOP. A load-immediate that targets memory is not allowed. Only part of the external-command field range is usable. Any byte that fits no pattern is flagged as illegal.

A fetch unit presents a byte with `op_valid`. One clock later the decoded word appears on the outputs, registered, with `dec_valid` high. The operand bytes that follow are fetched outside the block, using the reported length.

Control is a two-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No fresh result is on the outputs. |
| `ST_SHOW` | The outputs hold the decode of the byte accepted on the previous edge. |

| Transition | From | To | Condition |
|---|---|---|---|
| `T_WAIT` | `ST_IDLE` | `ST_IDLE` | `op_valid` is low |
| `T_CAPTURE` | `ST_IDLE` | `ST_SHOW` | `op_valid` is high |
| `T_RELOAD` | `ST_SHOW` | `ST_SHOW` | `op_valid` is high |
| `T_DRAIN` | `ST_SHOW` | `ST_IDLE` | `op_valid` is low |

Top module: `opdec_top`

## Requirements
- R1: While reset is asserted, and until the first accepted byte, `dec_valid` is 0 and every other output is 0.
- R2: A byte sampled with `op_valid` high is decoded onto the outputs at the next rising edge, with `dec_valid` high. After an edge where `op_valid` was low, `dec_valid` is 0 and all decode outputs keep their previous values. Class codes: HALT=0, NOP=1, MOVE=2, LOADI=3, ALUR=4, ALUI=5, ROTL=6, ROTR=7, JUMP=8, CALL=9, RET=10, INPUT=11, EXTCMD=12, ILLEGAL=13.
- R3: Bytes 0x00, 0x01 and 0xFF decode as HALT, with length 1 and the memory flag clear.
- R4: A byte 11dddsss decodes as MOVE, with length 1, `dec_dst`=ddd and `dec_src`=sss. The exceptions are 0xC0, which decodes as NOP (dst=0, src=0), and 0xFF, which is HALT.
- R5: A byte 10aaasss decodes as ALUR, with length 1, `dec_alu`=aaa and `dec_src`=sss. A byte 00aaa100 decodes as ALUI, with length 2 and `dec_alu`=aaa.
- R6: A byte 00ddd110 with ddd not equal to 111 decodes as LOADI, with length 2 and `dec_dst`=ddd. Byte 0x3E is ILLEGAL.
- R7: Register code 111 means memory at H:L. `dec_mem` is 1 exactly for an ALUR with source 111, and for a MOVE whose destination or source is 111.
- R8: Bytes 01ccc000 and 01ccc010 decode as JUMP and CALL, with length 3, `dec_cond_en`=1 and `dec_cond`=ccc. Bytes 0x44 and 0x46 decode as JUMP and CALL, with length 3 and `dec_cond_en`=0. A byte 00ccc011 decodes as a conditional RET with length 1. Byte 0x07 decodes as an unconditional RET.
- R9: Byte 0x41 decodes as INPUT, with length 1. For any other byte 01xxxxx1, call its bits [5:1] the command field. When that field is 8 to 31, the byte decodes as EXTCMD with length 1, `dec_xcmd`=field and `dec_xcmd_ok`=1. When the field is 1 to 7, the byte decodes as ILLEGAL with `dec_xcmd_ok`=0.
- R10: Byte 0x02 decodes as ROTL and byte 0x0A decodes as ROTR, both with length 1.
- R11: A field output that the decoded class does not use reads 0: dst, src, alu, cond, cond_en, xcmd and xcmd_ok.
- R12: Every byte not covered by R3 to R10 decodes as ILLEGAL, with length 1, all field outputs 0 and `dec_mem` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Marks `op_byte` as an opcode to decode |
| op_byte | input | 8 | Opcode byte |
| dec_valid | output | 1 | Outputs carry a fresh decode |
| dec_class | output | 4 | Instruction class code |
| dec_len | output | 2 | Instruction length in bytes (1 to 3) |
| dec_dst | output | 3 | Destination register code |
| dec_src | output | 3 | Source register code |
| dec_alu | output | 3 | ALU operation code |
| dec_cond | output | 3 | Condition code |
| dec_cond_en | output | 1 | Transfer is conditional |
| dec_mem | output | 1 | An operand is memory at H:L |
| dec_xcmd | output | 5 | External-command number |
| dec_xcmd_ok | output | 1 | External-command number lies in the usable range |

## Verification
Several decode functions can fire on the same byte. The sharpest case is 0xFF. It matches the move pattern with both fields set to memory, so the memory flag would be raised, but the HALT decode must win and clear that flag. The INPUT byte 0x41 and command fields 1 to 7 also share the external-command pattern, and they must not set the validity bit. The bench sweeps all 256 byte values back to back, so each of these overlaps arrives with a different class on either side of it. A scoreboard compares every output field against a model built from the requirements, and idle gaps check that the outputs are held.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int OP_W   = 8;
    localparam int FLD_W  = 3;
    localparam int XCMD_W = OP_W - FLD_W;
    localparam int LEN_W  = 2;

    // lowest usable external-command number
    localparam logic [XCMD_W-1:0] XCMD_LO = XCMD_W'(8);
    // register code selecting memory at H:L
    localparam logic [FLD_W-1:0]  REG_MEM = '1;

    typedef enum logic [3:0] {
        CL_HALT    = 4'd0,
        CL_NOP     = 4'd1,
        CL_MOVE    = 4'd2,
        CL_LOADI   = 4'd3,
        CL_ALUR    = 4'd4,
        CL_ALUI    = 4'd5,
        CL_ROTL    = 4'd6,
        CL_ROTR    = 4'd7,
        CL_JUMP    = 4'd8,
        CL_CALL    = 4'd9,
        CL_RET     = 4'd10,
        CL_INPUT   = 4'd11,
        CL_EXTCMD  = 4'd12,
        CL_ILLEGAL = 4'd13
    } op_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } dec_state_e;

    typedef struct packed {
        op_class_e         cls;
        logic [LEN_W-1:0]  len;
        logic [FLD_W-1:0]  dst;
        logic [FLD_W-1:0]  src;
        logic [FLD_W-1:0]  alu;
        logic [FLD_W-1:0]  cond;
        logic              cond_en;
        logic              mem;
        logic [XCMD_W-1:0] xcmd;
        logic              xcmd_ok;
    } dec_word_t;

endpackage

// File: rtl/opdec_class.sv
module opdec_class
    import opdec_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    output op_class_e        cls,
    output logic [LEN_W-1:0] len,
    output logic             cond_en
);

    logic [1:0]        grp;
    logic [FLD_W-1:0]  mid;
    logic [FLD_W-1:0]  low;
    logic [XCMD_W-1:0] cmd;

    assign grp = op[OP_W-1 -: 2];
    assign mid = op[2*FLD_W-1 -: FLD_W];
    assign low = op[FLD_W-1:0];
    assign cmd = op[XCMD_W:1];

    always_comb begin
        cls     = CL_ILLEGAL;
        len     = LEN_W'(1);
        cond_en = 1'b0;
        unique case (grp)
            2'b00: begin
                case (low)
                    3'b000, 3'b001: if (mid == '0) cls = CL_HALT;
                    3'b010: begin
                        if (mid == 3'd0)      cls = CL_ROTL;
                        else if (mid == 3'd1) cls = CL_ROTR;
                    end
                    3'b011: begin
                        cls     = CL_RET;
                        cond_en = 1'b1;
                    end
                    3'b100: begin
                        cls = CL_ALUI;
                        len = LEN_W'(2);
                    end
                    3'b110: begin
                        if (mid != REG_MEM) begin
                            cls = CL_LOADI;
                            len = LEN_W'(2);
                        end
                    end
                    3'b111: if (mid == '0) cls = CL_RET;
                    default: ;
                endcase
            end
            2'b01: begin
                if (low[0]) begin
                    if (cmd == '0)          cls = CL_INPUT;
                    else if (cmd >= XCMD_LO) cls = CL_EXTCMD;
                end else begin
                    case (low)
                        3'b000: begin
                            cls = CL_JUMP; len = LEN_W'(3); cond_en = 1'b1;
                        end
                        3'b010: begin
                            cls = CL_CALL; len = LEN_W'(3); cond_en = 1'b1;
                        end
                        3'b100: if (mid == '0) begin
                            cls = CL_JUMP; len = LEN_W'(3);
                        end
                        3'b110: if (mid == '0) begin
                            cls = CL_CALL; len = LEN_W'(3);
                        end
                        default: ;
                    endcase
                end
            end
            2'b10: cls = CL_ALUR;
            2'b11: begin
                if (op == '1)       cls = CL_HALT;
                else if (op[5:0] == '0) cls = CL_NOP;
                else                cls = CL_MOVE;
            end
        endcase
    end

endmodule

// File: rtl/opdec_fields.sv
module opdec_fields
    import opdec_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  op_class_e         cls,
    input  logic              cond_en,
    output logic [FLD_W-1:0]  dst,
    output logic [FLD_W-1:0]  src,
    output logic [FLD_W-1:0]  alu,
    output logic [FLD_W-1:0]  cond,
    output logic              mem,
    output logic [XCMD_W-1:0] xcmd,
    output logic              xcmd_ok
);

    logic [FLD_W-1:0] hi_f;
    logic [FLD_W-1:0] lo_f;
    logic             uses_dst;
    logic             uses_src;
    logic             uses_alu;

    assign hi_f = op[2*FLD_W-1 -: FLD_W];
    assign lo_f = op[FLD_W-1:0];

    assign uses_dst = (cls == CL_MOVE) || (cls == CL_NOP) || (cls == CL_LOADI);
    assign uses_src = (cls == CL_MOVE) || (cls == CL_NOP) || (cls == CL_ALUR);
    assign uses_alu = (cls == CL_ALUR) || (cls == CL_ALUI);

    always_comb begin
        dst     = uses_dst ? hi_f : '0;
        src     = uses_src ? lo_f : '0;
        alu     = uses_alu ? hi_f : '0;
        cond    = cond_en  ? hi_f : '0;
        mem     = ((cls == CL_ALUR) && (lo_f == REG_MEM)) ||
                  ((cls == CL_MOVE) && ((hi_f == REG_MEM) || (lo_f == REG_MEM)));
        xcmd_ok = (cls == CL_EXTCMD);
        xcmd    = xcmd_ok ? op[XCMD_W:1] : '0;
    end

endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    output logic              dec_valid,
    output logic [3:0]        dec_class,
    output logic [1:0]        dec_len,
    output logic [2:0]        dec_dst,
    output logic [2:0]        dec_src,
    output logic [2:0]        dec_alu,
    output logic [2:0]        dec_cond,
    output logic              dec_cond_en,
    output logic              dec_mem,
    output logic [4:0]        dec_xcmd,
    output logic              dec_xcmd_ok
);

    dec_state_e state_q, state_d;
    dec_word_t  word_c, word_q;
    op_class_e  cls_c;
    logic [LEN_W-1:0] len_c;
    logic       cond_en_c;

    opdec_class u_class (
        .op      (op_byte),
        .cls     (cls_c),
        .len     (len_c),
        .cond_en (cond_en_c)
    );

    opdec_fields u_fields (
        .op      (op_byte),
        .cls     (cls_c),
        .cond_en (cond_en_c),
        .dst     (word_c.dst),
        .src     (word_c.src),
        .alu     (word_c.alu),
        .cond    (word_c.cond),
        .mem     (word_c.mem),
        .xcmd    (word_c.xcmd),
        .xcmd_ok (word_c.xcmd_ok)
    );

    assign word_c.cls     = cls_c;
    assign word_c.len     = len_c;
    assign word_c.cond_en = cond_en_c;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: T_WAIT, T_CAPTURE, T_RELOAD, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = op_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = op_valid ? ST_SHOW : ST_IDLE;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (op_valid) word_q <= word_c;
    end

    assign dec_valid   = (state_q == ST_SHOW);
    assign dec_class   = word_q.cls;
    assign dec_len     = word_q.len;
    assign dec_dst     = word_q.dst;
    assign dec_src     = word_q.src;
    assign dec_alu     = word_q.alu;
    assign dec_cond    = word_q.cond;
    assign dec_cond_en = word_q.cond_en;
    assign dec_mem     = word_q.mem;
    assign dec_xcmd    = word_q.xcmd;
    assign dec_xcmd_ok = word_q.xcmd_ok;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> dec_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!dec_valid && $stable(dec_class) && $stable(dec_len))); // R2
    AST_MEM_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dec_mem |-> (dec_class == CL_ALUR || dec_class == CL_MOVE)); // R7
    AST_XCMD_OK_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_xcmd_ok |-> (dec_class == CL_EXTCMD && dec_xcmd >= XCMD_LO)); // R9
    AST_COND_ON_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        dec_cond_en |-> (dec_class == CL_JUMP || dec_class == CL_CALL || dec_class == CL_RET)); // R8
    AST_FAR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_class == CL_JUMP || dec_class == CL_CALL)) |-> dec_len == 2'd3); // R8
    AST_HALT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_class == CL_HALT) |-> (!dec_mem && dec_len == 2'd1)); // R3

endmodule

// File: tb/sim_opdec_top.sv
module sim_opdec_top;

    typedef struct packed {
        logic [3:0] cls;
        logic [1:0] len;
        logic [2:0] dst;
        logic [2:0] src;
        logic [2:0] alu;
        logic [2:0] cond;
        logic       cond_en;
        logic       mem;
        logic [4:0] xcmd;
        logic       xcmd_ok;
    } exp_t;

    typedef struct packed {
        logic  v;
        exp_t  e;
        logic [7:0] b;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic dec_valid, dec_cond_en, dec_mem, dec_xcmd_ok;
    logic [3:0] dec_class;
    logic [1:0] dec_len;
    logic [2:0] dec_dst, dec_src, dec_alu, dec_cond;
    logic [4:0] dec_xcmd;

    int checks = 0;
    int errors = 0;
    item_t q[$];
    exp_t  last_e = '0;

    always #4 clk = ~clk;

    opdec_top u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .dec_valid(dec_valid), .dec_class(dec_class), .dec_len(dec_len),
        .dec_dst(dec_dst), .dec_src(dec_src), .dec_alu(dec_alu),
        .dec_cond(dec_cond), .dec_cond_en(dec_cond_en), .dec_mem(dec_mem),
        .dec_xcmd(dec_xcmd), .dec_xcmd_ok(dec_xcmd_ok)
    );

    // expected decode, written from the requirements
    function automatic exp_t model(input logic [7:0] b);
        exp_t e = '0;
        e.cls = 4'd13;
        e.len = 2'd1;
        casez (b)
            8'b1111_1111, 8'b0000_000?: e.cls = 4'd0;                       // R3
            8'b1100_0000: e.cls = 4'd1;                                     // R4
            8'b11??_????: begin                                             // R4 R7
                e.cls = 4'd2; e.dst = b[5:3]; e.src = b[2:0];
                e.mem = (b[5:3] == 3'b111) || (b[2:0] == 3'b111);
            end
            8'b10??_????: begin                                             // R5 R7
                e.cls = 4'd4; e.alu = b[5:3]; e.src = b[2:0];
                e.mem = (b[2:0] == 3'b111);
            end
            8'b0000_0010: e.cls = 4'd6;                                     // R10
            8'b0000_1010: e.cls = 4'd7;                                     // R10
            8'b00??_?011: begin e.cls = 4'd10; e.cond_en = 1'b1; e.cond = b[5:3]; end // R8
            8'b0000_0111: e.cls = 4'd10;                                    // R8
            8'b00??_?100: begin e.cls = 4'd5; e.len = 2'd2; e.alu = b[5:3]; end // R5
            8'b0011_1110: e.cls = 4'd13;                                    // R6
            8'b00??_?110: begin e.cls = 4'd3; e.len = 2'd2; e.dst = b[5:3]; end // R6
            8'b0100_0001: e.cls = 4'd11;                                    // R9
            8'b01??_???1: begin                                             // R9
                if (b[5:1] >= 5'd8) begin
                    e.cls = 4'd12; e.xcmd = b[5:1]; e.xcmd_ok = 1'b1;
                end
            end
            8'b01??_?000: begin e.cls = 4'd8; e.len = 2'd3; e.cond_en = 1'b1; e.cond = b[5:3]; end // R8
            8'b01??_?010: begin e.cls = 4'd9; e.len = 2'd3; e.cond_en = 1'b1; e.cond = b[5:3]; end // R8
            8'b0100_0100: begin e.cls = 4'd8; e.len = 2'd3; end             // R8
            8'b0100_0110: begin e.cls = 4'd9; e.len = 2'd3; end             // R8
            default: ;                                                      // R12
        endcase
        return e;
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd0:  return "R3";
            4'd1, 4'd2: return "R4/R7/R11";
            4'd3:  return "R6/R11";
            4'd4, 4'd5: return "R5/R7/R11";
            4'd6, 4'd7: return "R10";
            4'd8, 4'd9, 4'd10: return "R8/R11";
            4'd11, 4'd12: return "R9/R11";
            default: return "R12";
        endcase
    endfunction

    function automatic exp_t actual();
        exp_t a;
        a.cls = dec_class; a.len = dec_len; a.dst = dec_dst; a.src = dec_src;
        a.alu = dec_alu; a.cond = dec_cond; a.cond_en = dec_cond_en;
        a.mem = dec_mem; a.xcmd = dec_xcmd; a.xcmd_ok = dec_xcmd_ok;
        return a;
    endfunction

    task automatic drive(input logic v, input logic [7:0] b);
        item_t it;
        @(negedge clk);
        op_valid = v;
        op_byte  = b;
        if (v) last_e = model(b);
        it.v = v; it.e = last_e; it.b = b;
        q.push_back(it);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                exp_t  a;
                it = q.pop_front();
                a  = actual();
                checks++;
                if (dec_valid !== it.v) begin
                    errors++;
                    $display("FAIL R2 valid op=%h got=%b exp=%b", it.b, dec_valid, it.v);
                end
                checks++;
                if (a !== it.e) begin
                    errors++;
                    if (it.v)
                        $display("FAIL %s op=%h got=%h exp=%h", tag_of(it.e.cls), it.b, a, it.e);
                    else
                        $display("FAIL R2 hold got=%h exp=%h", a, it.e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                checks++;                                           // R1 during reset
                if (dec_valid !== 1'b0 || actual() !== exp_t'(0)) begin
                    errors++;
                    $display("FAIL R1 got=%h/%b exp=0/0", actual(), dec_valid);
                end
                rst_n = 1'b1;
                @(negedge clk);
                checks++;                                           // R1 after reset
                if (dec_valid !== 1'b0 || actual() !== exp_t'(0)) begin
                    errors++;
                    $display("FAIL R1 got=%h/%b exp=0/0", actual(), dec_valid);
                end
                // full sweep, back to back
                for (int i = 0; i < 256; i++) drive(1'b1, 8'(i));
                // sweep downward with idle gaps to check holding (R2)
                for (int i = 255; i >= 0; i--) begin
                    drive(1'b1, 8'(i));
                    if (i % 7 == 0) begin
                        drive(1'b0, 8'hA5);
                        drive(1'b0, 8'h3C);
                    end
                end
                // overlapping-pattern bytes next to each other
                drive(1'b1, 8'hFF); drive(1'b1, 8'hC7); drive(1'b1, 8'h41);
                drive(1'b1, 8'h4F); drive(1'b1, 8'h51); drive(1'b1, 8'h3E);
                drive(1'b1, 8'hC0); drive(1'b0, 8'hFF);
                drive(1'b0, 8'h00);
                repeat (3) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        finish_run();
    end

endmodule